// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry step of exception handling for a small 32-bit RISC core. Each cycle it looks at a synchronous fault request with its cause code, the external interrupt line and the interrupt-enable state. When it accepts an entry, it computes the handler fetch address and stores the current program counter in a link register. It also produces the updated interrupt-enable bits.

Causes fall into two classes. Normal causes save the PC into the exception link register. They keep the old global enable in a normal shadow bit and vector from the exception base. A remap control moves normal causes to the debug base instead. Debug causes (breakpoint, watchpoint) save the PC into the breakpoint link register. They keep the old global enable in a debug shadow bit and always vector from the debug base.

The block takes a decision every cycle. All results are registered and appear in the following cycle as one-cycle strobes. The core's register file and fetch unit act on those strobes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The handler address is the selected base plus the cause code times 32 (modulo 2^32). Cause codes are: 0 reset, 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call.
- R2: Normal entries save the PC with `save_sel`=0, which selects the exception link register. Normal entries are causes 2, 4, 5, 7 and an accepted interrupt (6).
- R3: On a normal entry, `ie_next` copies IE into EIE and clears IE, and BIE is unchanged. The bit layout is IE=bit0, EIE=bit1, BIE=bit2.
- R4: A normal entry uses `deba_i` as its base when `remap_en` is 1 and `eba_i` when it is 0.
- R5: A debug entry (cause 1 or 3) has `save_sel`=1, selecting the breakpoint link register. On a debug entry, `ie_next` copies IE into BIE and clears IE, EIE is unchanged, and the base is always `deba_i`, whatever `remap_en` is.
- R6: The interrupt line is accepted only when IE (bit0 of `ie_i`) is 1. Otherwise nothing is produced.
- R7: A valid fault request in the same cycle as the interrupt line wins, and the interrupt is not accepted in that cycle. It is taken in a later cycle if it is still asserted.
- R8: An entry decided in cycle N appears in cycle N+1. At that point `redirect_vld`, `save_we` and `ie_we` are all 1 for that single cycle, `redirect_pc` holds the target and `save_data` holds the PC from cycle N.
- R9: A fault request with cause 0 or 6 pulses `cause_err` in the next cycle. That cycle has no redirect, no save and no enable write, even if the interrupt line is asserted.
- R10: While reset is asserted and after its release with no request, all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous fault request |
| exc_cause | input | 3 | Cause code of the fault request |
| irq_line | input | 1 | External interrupt level |
| pc_i | input | 32 | PC of the current instruction |
| eba_i | input | 32 | Exception base |
| deba_i | input | 32 | Debug exception base |
| remap_en | input | 1 | Send normal causes to the debug base |
| ie_i | input | 3 | Current enable bits {BIE, EIE, IE} |
| redirect_vld | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Handler address |
| save_we | output | 1 | Link register write strobe |
| save_sel | output | 1 | 0 = exception link, 1 = breakpoint link |
| save_data | output | 32 | Saved PC |
| ie_we | output | 1 | Enable register write strobe |
| ie_next | output | 3 | New enable bits {BIE, EIE, IE} |
| cause_err | output | 1 | Unrecognised cause pulse |

## Verification
A synchronous fault request and the interrupt line can both be active in one cycle. So can an unrecognised cause and the interrupt line. The bench sweeps every cause code, both request and interrupt levels, all eight enable patterns and both remap settings. This covers every such collision. Each response is judged against an arithmetic model that lets the valid fault win, blocks everything on an error, and accepts the interrupt only when IE is set.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int unsigned CAUSE_W = 3;
   localparam int unsigned EN_W    = 3;
   localparam int unsigned EN_GLB  = 0;
   localparam int unsigned EN_NRM  = 1;
   localparam int unsigned EN_DBG  = 2;

   typedef enum logic [CAUSE_W-1:0] {
      CZ_RESET  = 3'd0,
      CZ_BKPT   = 3'd1,
      CZ_IBUS   = 3'd2,
      CZ_WATCH  = 3'd3,
      CZ_DBUS   = 3'd4,
      CZ_DIVZ   = 3'd5,
      CZ_IRQ    = 3'd6,
      CZ_SCALL  = 3'd7
   } cause_e;

   function automatic logic cause_is_debug(input logic [CAUSE_W-1:0] c);
      return (c == CZ_BKPT) || (c == CZ_WATCH);
   endfunction
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
   import exc_entry_pkg::*;
(
   input  logic               req,
   input  logic [CAUSE_W-1:0] cause,
   output logic               accept,
   output logic               reject
);
   always_comb begin
      accept = 1'b0;
      reject = 1'b0;
      if (req) begin
         unique case (cause_e'(cause))
            CZ_BKPT, CZ_IBUS, CZ_WATCH,
            CZ_DBUS, CZ_DIVZ, CZ_SCALL: accept = 1'b1;
            default:                    reject = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_entry_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned SLOT_SHIFT   = 5,
   parameter bit          ALIGNED_BASE = 1'b0
) (
   input  logic [CAUSE_W-1:0] cause,
   input  logic               use_dbg_base,
   input  logic [XLEN-1:0]    eba,
   input  logic [XLEN-1:0]    deba,
   output logic [XLEN-1:0]    target
);
   localparam int unsigned OFF_W = CAUSE_W + SLOT_SHIFT;

   logic [XLEN-1:0]  base;
   logic [OFF_W-1:0] offset;

   assign base   = use_dbg_base ? deba : eba;
   assign offset = {cause, {SLOT_SHIFT{1'b0}}};

   generate
      if (ALIGNED_BASE) begin : g_concat
         assign target = {base[XLEN-1:OFF_W], offset};
      end else begin : g_adder
         assign target = base + XLEN'(offset);
      end
   endgenerate
endmodule

// File: rtl/exc_ie_update.sv
module exc_ie_update
   import exc_entry_pkg::*;
(
   input  logic [EN_W-1:0] ie_cur,
   input  logic            debug_class,
   output logic [EN_W-1:0] ie_new
);
   always_comb begin
      ie_new         = ie_cur;
      ie_new[EN_GLB] = 1'b0;
      if (debug_class) ie_new[EN_DBG] = ie_cur[EN_GLB];
      else             ie_new[EN_NRM] = ie_cur[EN_GLB];
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned SLOT_SHIFT   = 5,
   parameter bit          ALIGNED_BASE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [CAUSE_W-1:0] exc_cause,
   input  logic               irq_line,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [XLEN-1:0]    eba_i,
   input  logic [XLEN-1:0]    deba_i,
   input  logic               remap_en,
   input  logic [EN_W-1:0]    ie_i,
   output logic               redirect_vld,
   output logic [XLEN-1:0]    redirect_pc,
   output logic               save_we,
   output logic               save_sel,
   output logic [XLEN-1:0]    save_data,
   output logic               ie_we,
   output logic [EN_W-1:0]    ie_next,
   output logic               cause_err
);
   generate
      if (XLEN < CAUSE_W + SLOT_SHIFT) begin : g_bad_width
         $error("exc_entry_ctrl: XLEN too small for vector table");
      end
   endgenerate

   logic               f_ok, f_bad, irq_take, fire, dbg;
   logic [CAUSE_W-1:0] eff_cause;
   logic [XLEN-1:0]    tgt;
   logic [EN_W-1:0]    ie_calc;

   exc_cause_decode u_dec (
      .req    (exc_req),
      .cause  (exc_cause),
      .accept (f_ok),
      .reject (f_bad)
   );

   assign irq_take  = !exc_req && irq_line && ie_i[EN_GLB];
   assign fire      = f_ok || irq_take;
   assign eff_cause = f_ok ? exc_cause : CAUSE_W'(CZ_IRQ);
   assign dbg       = cause_is_debug(eff_cause);

   exc_vector_gen #(
      .XLEN         (XLEN),
      .SLOT_SHIFT   (SLOT_SHIFT),
      .ALIGNED_BASE (ALIGNED_BASE)
   ) u_vec (
      .cause        (eff_cause),
      .use_dbg_base (dbg || remap_en),
      .eba          (eba_i),
      .deba         (deba_i),
      .target       (tgt)
   );

   exc_ie_update u_ie (
      .ie_cur      (ie_i),
      .debug_class (dbg),
      .ie_new      (ie_calc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_vld <= 1'b0;
         redirect_pc  <= '0;
         save_we      <= 1'b0;
         save_sel     <= 1'b0;
         save_data    <= '0;
         ie_we        <= 1'b0;
         ie_next      <= '0;
         cause_err    <= 1'b0;
      end else begin
         redirect_vld <= fire;
         save_we      <= fire;
         ie_we        <= fire;
         cause_err    <= f_bad;
         redirect_pc  <= fire ? tgt     : '0;
         save_sel     <= fire ? dbg     : 1'b0;
         save_data    <= fire ? pc_i    : '0;
         ie_next      <= fire ? ie_calc : '0;
      end
   end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
   import exc_entry_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [CAUSE_W-1:0] exc_cause,
   input  logic               irq_line,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [XLEN-1:0]    deba_i,
   input  logic [EN_W-1:0]    ie_i,
   input  logic               redirect_vld,
   input  logic [XLEN-1:0]    redirect_pc,
   input  logic               save_we,
   input  logic [XLEN-1:0]    save_data,
   input  logic               ie_we,
   input  logic [EN_W-1:0]    ie_next,
   input  logic               cause_err
);
   p_strobes_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_vld == save_we) && (save_we == ie_we));

   p_saved_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !(exc_cause == 3'd0 || exc_cause == 3'd6)) |=> (save_we && save_data == $past(pc_i)));

   p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && irq_line && !ie_i[EN_GLB]) |=> !redirect_vld);

   p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cause_err |-> (!redirect_vld && !save_we && !ie_we));

   p_ie_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ie_we |-> !ie_next[EN_GLB]);

   p_bkpt_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && exc_cause == 3'd1) |=> (redirect_pc == $past(deba_i) + XLEN'(32)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .exc_req      (exc_req),
   .exc_cause    (exc_cause),
   .irq_line     (irq_line),
   .pc_i         (pc_i),
   .deba_i       (deba_i),
   .ie_i         (ie_i),
   .redirect_vld (redirect_vld),
   .redirect_pc  (redirect_pc),
   .save_we      (save_we),
   .save_data    (save_data),
   .ie_we        (ie_we),
   .ie_next      (ie_next),
   .cause_err    (cause_err)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [2:0]  exc_cause = '0;
   logic        irq_line = 1'b0;
   logic [31:0] pc_i = '0, eba_i = '0, deba_i = '0;
   logic        remap_en = 1'b0;
   logic [2:0]  ie_i = '0;
   logic        redirect_vld, save_we, save_sel, ie_we, cause_err;
   logic [31:0] redirect_pc, save_data;
   logic [2:0]  ie_next;

   int n_chk = 0, n_fail = 0, cycles = 0;

   always #2.5 clk = ~clk;

   exc_entry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
      .irq_line(irq_line), .pc_i(pc_i), .eba_i(eba_i), .deba_i(deba_i),
      .remap_en(remap_en), .ie_i(ie_i), .redirect_vld(redirect_vld),
      .redirect_pc(redirect_pc), .save_we(save_we), .save_sel(save_sel),
      .save_data(save_data), .ie_we(ie_we), .ie_next(ie_next),
      .cause_err(cause_err)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         finish_run();
      end
   end

   task automatic idle_check();
      @(negedge clk);
      exc_req  = 1'b0;
      irq_line = 1'b0;
      @(negedge clk);
      check("R8 strobe drops after one cycle", {redirect_vld, save_we, ie_we, cause_err}, 4'b0000);
   endtask

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      check("R10 reset strobes", {redirect_vld, save_we, ie_we, cause_err}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", {redirect_vld, save_we, ie_we, cause_err}, 4'b0000);

      // Exhaustive sweep of request, cause, irq, enable bits, remap
      for (int rq = 0; rq < 2; rq++)
      for (int c = 0; c < 8; c++)
      for (int ir = 0; ir < 2; ir++)
      for (int ie = 0; ie < 8; ie++)
      for (int rm = 0; rm < 2; rm++) begin
         logic        ok, bad, take_irq, fire, dbg;
         logic [2:0]  ec, exp_ie;
         logic [31:0] base, exp_pc;
         int          idx;
         idx = (((rq * 8 + c) * 2 + ir) * 8 + ie) * 2 + rm;
         @(negedge clk);
         exc_req   = rq[0];
         exc_cause = c[2:0];
         irq_line  = ir[0];
         ie_i      = ie[2:0];
         remap_en  = rm[0];
         pc_i      = 32'h1000_0000 + 32'(idx) * 4;
         eba_i     = 32'h0004_0000 ^ (32'(idx) << 8);
         deba_i    = (idx % 5 == 0) ? 32'hFFFF_FF80 : 32'h0080_0000 + 32'(idx) * 16;
         ok        = rq[0] && !(c == 0 || c == 6);
         bad       = rq[0] && (c == 0 || c == 6);
         take_irq  = !rq[0] && ir[0] && ie[0];
         fire      = ok || take_irq;
         ec        = ok ? c[2:0] : 3'd6;
         dbg       = (ec == 3'd1) || (ec == 3'd3);
         base      = (dbg || rm[0]) ? deba_i : eba_i;
         exp_pc    = base + {ec, 5'b0};
         exp_ie    = dbg ? {ie[0], ie[1], 1'b0} : {ie[2], ie[0], 1'b0};
         @(negedge clk);
         exc_req  = 1'b0;
         irq_line = 1'b0;
         if (bad) begin
            check("R9 error pulse, no entry", {cause_err, redirect_vld, save_we, ie_we}, 4'b1000);
         end else if (!rq[0] && ir[0] && !ie[0]) begin
            check("R6 masked interrupt ignored", {redirect_vld, save_we, ie_we}, 3'b000);
         end else if (ok && ir[0]) begin
            check("R7 fault wins over irq", {redirect_vld, 29'd0, save_sel, redirect_pc}, {1'b1, 29'd0, dbg, exp_pc});
         end else if (!fire) begin
            check("R10 no request no strobe", {redirect_vld, save_we, ie_we, cause_err}, 4'b0000);
         end
         if (fire) begin
            check("R8 strobes together", {redirect_vld, save_we, ie_we, cause_err}, 4'b1110);
            check("R8 saved pc", save_data, pc_i);
            if (dbg) begin
               check("R5 debug target/link/ie", {redirect_pc, save_sel, ie_next}, {exp_pc, 1'b1, exp_ie});
            end else begin
               check("R1 R4 normal target", redirect_pc, exp_pc);
               check("R2 normal link select", save_sel, 1'b0);
               check("R3 normal ie update", ie_next, exp_ie);
            end
         end
      end

      // R7: interrupt held through a fault is taken next cycle
      @(negedge clk);
      ie_i = 3'b001; remap_en = 1'b0; eba_i = 32'h0000_4000; deba_i = 32'h0000_8000;
      pc_i = 32'h0000_0100; exc_req = 1'b1; exc_cause = 3'd4; irq_line = 1'b1;
      @(negedge clk);
      check("R7 fault taken first", redirect_pc, 32'h0000_4080);
      exc_req = 1'b0; pc_i = 32'h0000_0104;
      @(negedge clk);
      check("R7 pending irq taken after", {redirect_vld, redirect_pc}, {1'b1, 32'h0000_40C0});
      idle_check();

      finish_run();
   end
endmodule